// File: doc/BRIEF.md
# Shared Cache Maintenance Command Queue

This block is the register front-end of an outer cache controller that accepts maintenance commands from several processors over one register bus. Each access carries the requesting processor's index. A small set of command registers is shared: a mode word, a start address, a byte count, an address mask and a way selector. Hardware arbitration makes each processor's registration sequence atomic. The processor that writes the mode word first owns these registers. It keeps them until it reads its own registration-status word. That read closes the registration and pushes the command into a FIFO when there is room.

Queued commands go, strictly one at a time, to a stub execution engine. The engine pulses a done strobe a fixed, parameterised number of cycles after it starts each entry. Every processor has a private completion flag that is set when one of its commands, registered with notification, finishes. Software clears the flag by writing a one to it. A read of the primitive register stalls the bus until all queued and running work has drained. A write of 0x9 to that register emits a one-cycle prefetch-buffer flush strobe.

Top module: `cmq_top`

## Requirements
- R1: With no owner, a write to the mode word (offset 0x248) by processor c makes c the owner and stores the word. While c owns them, writes from any other processor to the mode, address (0x24C), size (0x250), mask (0x254) or way (0x258) registers are dropped. With no owner, writes to the address, size, mask and way registers are also dropped. All five registers read back their stored value.
- R2: When the owner reads the registration-status word (0x25C), ownership ends. If the FIFO has room, the command is pushed and the read returns 0. If the FIFO is full, the command is discarded and the read returns 2 (bit 1 set).
- R3: A read of the registration-status word by any processor that is not the current owner returns 1 (bit 0 set) and changes no state.
- R4: The mode word is decoded as follows. Bits 3:0 give the command code. Bit 15 requests notification. Bits 18:17 give the scope: 0 address range, 1 whole cache, 2 by way. Bits 22:21 give the target: 0 data LRU, 1 instruction LRU, 2 by way. The engine receives the stored address and size only for scope 0, and zero otherwise. It receives the stored way value only for target 2, and zero otherwise.
- R5: Accepted commands start in acceptance order. A command starts only after the previous one has raised done.
- R6: `exec_done_o` is high for exactly one cycle, LAT cycles after the cycle in which `exec_start_o` is high.
- R7: Bit 2 of the per-processor queue-status word (0x260) is that processor's completion flag. It is set after done for one of its commands that had notification requested. A write to 0x260 with bit 2 = 1 clears the writer's flag, and a write with bit 2 = 0 leaves it. If a set and a clear fall in the same cycle, the set wins.
- R8: In the queue-status word, bit 1 reads 1 while the engine is running a command, and bit 0 reads 1 while the FIFO holds waiting entries.
- R9: A read of the primitive register (0x244) holds `bus_ready_o` low while the engine is busy or the FIFO is non-empty. It completes once both are clear and returns 0.
- R10: A write of 0x9 to the primitive register raises `pf_flush_o` for one cycle, in the cycle after the write. Any other value written there gives no strobe.
- R11: After reset there is no owner and the FIFO is empty. All flags are clear, `bus_ready_o` is 1, and the shared registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid_i | input | 1 | Register access request |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_cpu_i | input | IDW | Index of the requesting processor |
| bus_addr_i | input | 12 | Byte offset within the register window |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the accepted cycle |
| bus_ready_o | output | 1 | Access accepted this cycle |
| exec_start_o | output | 1 | Engine begins an entry |
| exec_done_o | output | 1 | Engine finished its entry |
| exec_cpu_o | output | IDW | Processor that registered the running entry |
| exec_cmd_o | output | 4 | Command code of the running entry |
| exec_scope_o | output | 2 | Scope field of the running entry |
| exec_target_o | output | 2 | Target field of the running entry |
| exec_addr_o | output | 32 | Start address (0 unless scope is range) |
| exec_size_o | output | 32 | Byte count (0 unless scope is range) |
| exec_way_o | output | 32 | Way selector (0 unless target is by way) |
| pf_flush_o | output | 1 | Prefetch-buffer flush strobe |

## Verification
Two functions can meet in one cycle: the engine's done, which sets a processor's completion flag, and that same processor's write-one-to-clear of the flag. The bench watches `exec_done_o` at the falling edge. In that same cycle it drives the clear write from the processor that owns the finishing entry. It then reads the queue-status word back, and the flag must still be set. The bench also reads queue status while one entry is running and others are waiting, so that push and pop activity share cycles with status reads.

// File: rtl/cmq_pkg.sv
package cmq_pkg;
  localparam int unsigned REG_W  = 32;
  localparam int unsigned OFFS_W = 12;

  localparam logic [OFFS_W-1:0] OFF_PRIM  = 12'h244;
  localparam logic [OFFS_W-1:0] OFF_MODE  = 12'h248;
  localparam logic [OFFS_W-1:0] OFF_ADDR  = 12'h24C;
  localparam logic [OFFS_W-1:0] OFF_SIZE  = 12'h250;
  localparam logic [OFFS_W-1:0] OFF_MASK  = 12'h254;
  localparam logic [OFFS_W-1:0] OFF_WAY   = 12'h258;
  localparam logic [OFFS_W-1:0] OFF_SETC  = 12'h25C;
  localparam logic [OFFS_W-1:0] OFF_QSTAT = 12'h260;

  localparam logic [REG_W-1:0] PRIM_PF_FLUSH = 32'h9;

  typedef enum logic [1:0] {SC_RANGE = 2'd0, SC_ALL = 2'd1, SC_WAY = 2'd2, SC_RSVD = 2'd3} scope_e;
  typedef enum logic [1:0] {TG_DATA = 2'd0, TG_INST = 2'd1, TG_WAY = 2'd2, TG_RSVD = 2'd3} target_e;

  typedef struct packed {
    logic [3:0]       cmd;
    scope_e           scope;
    target_e          tgt;
    logic             notify;
    logic [REG_W-1:0] addr;
    logic [REG_W-1:0] size;
    logic [REG_W-1:0] way;
  } cmd_t;
endpackage

// File: rtl/cmq_fifo.sv
module cmq_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [W-1:0]  din_i,
  output logic [W-1:0]  dout_o,
  output logic          empty_o,
  output logic          full_o,
  output logic [CW-1:0] count_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign count_o = cnt_q;
  assign dout_o  = mem_q[rd_q];
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;

  always_comb begin
    wr_d  = do_push ? step(wr_q) : wr_q;
    rd_d  = do_pop  ? step(rd_q) : rd_q;
    cnt_d = cnt_q;
    if (do_push && !do_pop)      cnt_d = cnt_q + 1'b1;
    else if (do_pop && !do_push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem_q[wr_q] <= din_i;
  end
endmodule

// File: rtl/cmq_engine.sv
module cmq_engine #(
  parameter int unsigned W   = 8,
  parameter int unsigned LAT = 5,
  localparam int unsigned CNTW = $clog2(LAT + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid_i,
  input  logic [W-1:0] in_data_i,
  output logic         pop_o,
  output logic         start_o,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] data_o
);
  logic            busy_q, busy_d, start_q;
  logic [CNTW-1:0] cnt_q, cnt_d;
  logic [W-1:0]    data_q;

  assign pop_o   = !busy_q && in_valid_i;
  assign done_o  = busy_q && (cnt_q == '0);
  assign busy_o  = busy_q;
  assign start_o = start_q;
  assign data_o  = data_q;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (pop_o) begin
      busy_d = 1'b1;
      cnt_d  = CNTW'(LAT);
    end else if (done_o) begin
      busy_d = 1'b0;
    end else if (busy_q) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      start_q <= 1'b0;
      data_q  <= '0;
    end else begin
      busy_q  <= busy_d;
      cnt_q   <= cnt_d;
      start_q <= pop_o;
      if (pop_o) data_q <= in_data_i;
    end
  end
endmodule

// File: rtl/cmq_top.sv
module cmq_top
  import cmq_pkg::*;
#(
  parameter int unsigned NCPU  = 4,
  parameter int unsigned DEPTH = 4,
  parameter int unsigned LAT   = 5,
  localparam int unsigned IDW  = (NCPU > 1) ? $clog2(NCPU) : 1,
  localparam int unsigned EW   = $bits(cmd_t) + IDW,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid_i,
  input  logic              bus_write_i,
  input  logic [IDW-1:0]    bus_cpu_i,
  input  logic [OFFS_W-1:0] bus_addr_i,
  input  logic [REG_W-1:0]  bus_wdata_i,
  output logic [REG_W-1:0]  bus_rdata_o,
  output logic              bus_ready_o,
  output logic              exec_start_o,
  output logic              exec_done_o,
  output logic [IDW-1:0]    exec_cpu_o,
  output logic [3:0]        exec_cmd_o,
  output logic [1:0]        exec_scope_o,
  output logic [1:0]        exec_target_o,
  output logic [REG_W-1:0]  exec_addr_o,
  output logic [REG_W-1:0]  exec_size_o,
  output logic [REG_W-1:0]  exec_way_o,
  output logic              pf_flush_o
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s_n = rs_q[1];

  logic [REG_W-1:0] mode_q, mode_d, addr_q, addr_d, size_q, size_d;
  logic [REG_W-1:0] mask_q, mask_d, way_q, way_d;
  logic             hold_q, hold_d, pf_q, pf_d;
  logic [IDW-1:0]   holder_q, holder_d;
  logic [NCPU-1:0]  flag_q, flag_d;

  logic             acc, wr, rd, is_holder, push;
  logic             fifo_empty, fifo_full, eng_pop, eng_busy;
  logic [CW-1:0]    fifo_cnt;
  logic [EW-1:0]    fifo_din, fifo_dout, eng_data;
  cmd_t             new_cmd, run_cmd;
  logic             exec_notify;

  assign bus_ready_o = !(bus_valid_i && !bus_write_i && (bus_addr_i == OFF_PRIM) &&
                         (eng_busy || !fifo_empty));
  assign acc       = bus_valid_i && bus_ready_o;
  assign wr        = acc && bus_write_i;
  assign rd        = acc && !bus_write_i;
  assign is_holder = hold_q && (holder_q == bus_cpu_i);

  // command assembled from the shared registers at registration close
  always_comb begin
    new_cmd.cmd    = mode_q[3:0];
    new_cmd.notify = mode_q[15];
    new_cmd.scope  = scope_e'(mode_q[18:17]);
    new_cmd.tgt    = target_e'(mode_q[22:21]);
    new_cmd.addr   = (new_cmd.scope == SC_RANGE) ? addr_q : '0;
    new_cmd.size   = (new_cmd.scope == SC_RANGE) ? size_q : '0;
    new_cmd.way    = (new_cmd.tgt == TG_WAY) ? way_q : '0;
  end
  assign fifo_din = {holder_q, new_cmd};

  // arbitration and shared register writes
  always_comb begin
    mode_d   = mode_q;
    addr_d   = addr_q;
    size_d   = size_q;
    mask_d   = mask_q;
    way_d    = way_q;
    hold_d   = hold_q;
    holder_d = holder_q;
    push     = 1'b0;
    if (wr) begin
      case (bus_addr_i)
        OFF_MODE: if (!hold_q || is_holder) begin
          mode_d   = bus_wdata_i;
          hold_d   = 1'b1;
          holder_d = bus_cpu_i;
        end
        OFF_ADDR: if (is_holder) addr_d = bus_wdata_i;
        OFF_SIZE: if (is_holder) size_d = bus_wdata_i;
        OFF_MASK: if (is_holder) mask_d = bus_wdata_i;
        OFF_WAY:  if (is_holder) way_d  = bus_wdata_i;
        default: ;
      endcase
    end
    if (rd && (bus_addr_i == OFF_SETC) && is_holder) begin
      hold_d = 1'b0;
      push   = !fifo_full;
    end
  end

  assign pf_d = wr && (bus_addr_i == OFF_PRIM) && (bus_wdata_i == PRIM_PF_FLUSH);

  // per-processor completion flags; set has priority over clear
  for (genvar i = 0; i < NCPU; i++) begin : g_flag
    always_comb begin
      flag_d[i] = flag_q[i];
      if (wr && (bus_addr_i == OFF_QSTAT) && (bus_cpu_i == IDW'(i)) && bus_wdata_i[2])
        flag_d[i] = 1'b0;
      if (exec_done_o && exec_notify && (exec_cpu_o == IDW'(i)))
        flag_d[i] = 1'b1;
    end
  end

  always_comb begin
    case (bus_addr_i)
      OFF_MODE:  bus_rdata_o = mode_q;
      OFF_ADDR:  bus_rdata_o = addr_q;
      OFF_SIZE:  bus_rdata_o = size_q;
      OFF_MASK:  bus_rdata_o = mask_q;
      OFF_WAY:   bus_rdata_o = way_q;
      OFF_SETC:  bus_rdata_o = is_holder ? (fifo_full ? 32'h2 : 32'h0) : 32'h1;
      OFF_QSTAT: bus_rdata_o = {29'd0, flag_q[bus_cpu_i], eng_busy, !fifo_empty};
      default:   bus_rdata_o = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      mode_q   <= '0;
      addr_q   <= '0;
      size_q   <= '0;
      mask_q   <= '0;
      way_q    <= '0;
      hold_q   <= 1'b0;
      holder_q <= '0;
      flag_q   <= '0;
      pf_q     <= 1'b0;
    end else begin
      mode_q   <= mode_d;
      addr_q   <= addr_d;
      size_q   <= size_d;
      mask_q   <= mask_d;
      way_q    <= way_d;
      hold_q   <= hold_d;
      holder_q <= holder_d;
      flag_q   <= flag_d;
      pf_q     <= pf_d;
    end
  end
  assign pf_flush_o = pf_q;

  cmq_fifo #(.W(EW), .DEPTH(DEPTH)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .push_i  (push),
    .pop_i   (eng_pop),
    .din_i   (fifo_din),
    .dout_o  (fifo_dout),
    .empty_o (fifo_empty),
    .full_o  (fifo_full),
    .count_o (fifo_cnt)
  );

  cmq_engine #(.W(EW), .LAT(LAT)) u_eng (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .in_valid_i (!fifo_empty),
    .in_data_i  (fifo_dout),
    .pop_o      (eng_pop),
    .start_o    (exec_start_o),
    .busy_o     (eng_busy),
    .done_o     (exec_done_o),
    .data_o     (eng_data)
  );

  assign exec_cpu_o    = eng_data[EW-1 -: IDW];
  assign run_cmd       = eng_data[$bits(cmd_t)-1:0];
  assign exec_notify   = run_cmd.notify;
  assign exec_cmd_o    = run_cmd.cmd;
  assign exec_scope_o  = run_cmd.scope;
  assign exec_target_o = run_cmd.tgt;
  assign exec_addr_o   = run_cmd.addr;
  assign exec_size_o   = run_cmd.size;
  assign exec_way_o    = run_cmd.way;
endmodule

// File: rtl/cmq_chk.sv
module cmq_chk
  import cmq_pkg::*;
#(
  parameter int unsigned NCPU  = 4,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned IDW  = (NCPU > 1) ? $clog2(NCPU) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid_i,
  input logic              bus_write_i,
  input logic [IDW-1:0]    bus_cpu_i,
  input logic [OFFS_W-1:0] bus_addr_i,
  input logic [REG_W-1:0]  bus_wdata_i,
  input logic              bus_ready_o,
  input logic              pf_flush_o,
  input logic              hold_q,
  input logic [IDW-1:0]    holder_q,
  input logic [CW-1:0]     fifo_cnt,
  input logic              fifo_full,
  input logic              push,
  input logic              exec_start_o,
  input logic              exec_done_o,
  input logic              exec_notify,
  input logic [IDW-1:0]    exec_cpu_o,
  input logic [NCPU-1:0]   flag_q
);
  logic acc_w;
  assign acc_w = bus_valid_i && bus_ready_o && bus_write_i;

  p_claim_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_w && bus_addr_i == OFF_MODE && !hold_q) |=> (hold_q && holder_q == $past(bus_cpu_i)));

  p_keep_owner_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_w && bus_addr_i == OFF_MODE && hold_q && bus_cpu_i != holder_q) |=> (hold_q && $stable(holder_q)));

  p_push_room_r2: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !fifo_full);

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt <= CW'(DEPTH));

  p_start_not_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    exec_start_o |-> !exec_done_o);

  p_flag_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_done_o && exec_notify) |=> flag_q[$past(exec_cpu_o)]);

  p_stall_only_prim_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ready_o |-> (bus_valid_i && !bus_write_i && bus_addr_i == OFF_PRIM));

  p_pf_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_w && bus_addr_i == OFF_PRIM && bus_wdata_i == PRIM_PF_FLUSH) |=> pf_flush_o);
endmodule

bind cmq_top cmq_chk #(.NCPU(NCPU), .DEPTH(DEPTH)) u_chk (
  .clk          (clk),
  .rst_n        (rst_s_n),
  .bus_valid_i  (bus_valid_i),
  .bus_write_i  (bus_write_i),
  .bus_cpu_i    (bus_cpu_i),
  .bus_addr_i   (bus_addr_i),
  .bus_wdata_i  (bus_wdata_i),
  .bus_ready_o  (bus_ready_o),
  .pf_flush_o   (pf_flush_o),
  .hold_q       (hold_q),
  .holder_q     (holder_q),
  .fifo_cnt     (fifo_cnt),
  .fifo_full    (fifo_full),
  .push         (push),
  .exec_start_o (exec_start_o),
  .exec_done_o  (exec_done_o),
  .exec_notify  (exec_notify),
  .exec_cpu_o   (exec_cpu_o),
  .flag_q       (flag_q)
);

// File: tb/cmq_top_test.sv
module cmq_top_test;
  localparam int unsigned LAT = 40;
  localparam logic [11:0] A_PRIM = 12'h244, A_MODE = 12'h248, A_ADDR = 12'h24C,
                          A_SIZE = 12'h250, A_MASK = 12'h254, A_WAY = 12'h258,
                          A_SETC = 12'h25C, A_QST = 12'h260;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [1:0]  bus_cpu = '0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_ready, exec_start, exec_done, pf_flush;
  logic [1:0]  exec_cpu, exec_scope, exec_target;
  logic [3:0]  exec_cmd;
  logic [31:0] exec_addr, exec_size, exec_way;

  always #4 clk = ~clk;

  cmq_top #(.NCPU(4), .DEPTH(4), .LAT(LAT)) uut (
    .clk(clk), .rst_n(rst_n),
    .bus_valid_i(bus_valid), .bus_write_i(bus_write), .bus_cpu_i(bus_cpu),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .bus_ready_o(bus_ready), .exec_start_o(exec_start), .exec_done_o(exec_done),
    .exec_cpu_o(exec_cpu), .exec_cmd_o(exec_cmd), .exec_scope_o(exec_scope),
    .exec_target_o(exec_target), .exec_addr_o(exec_addr), .exec_size_o(exec_size),
    .exec_way_o(exec_way), .pf_flush_o(pf_flush)
  );

  int ntest = 0, nfail = 0, cyc = 0, ns = 0, nd = 0;
  bit finished = 1'b0;
  int          st_cyc [16];
  int          dn_cyc [16];
  logic [1:0]  st_cpu [16];
  logic [3:0]  st_cmd [16];
  logic [31:0] st_addr [16], st_size [16], st_way [16];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (exec_start && ns < 16) begin
      st_cyc[ns] = cyc; st_cpu[ns] = exec_cpu; st_cmd[ns] = exec_cmd;
      st_addr[ns] = exec_addr; st_size[ns] = exec_size; st_way[ns] = exec_way;
      ns = ns + 1;
    end
    if (exec_done && nd < 16) begin
      dn_cyc[nd] = cyc;
      nd = nd + 1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    ntest++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at a falling edge, wait for acceptance, return at the next falling edge
  task automatic bus_op(input logic w, input logic [1:0] c, input logic [11:0] a,
                        input logic [31:0] d, output logic [31:0] r);
    bus_valid = 1'b1; bus_write = w; bus_cpu = c; bus_addr = a; bus_wdata = d;
    #1;
    while (!bus_ready) begin
      @(negedge clk);
      #1;
    end
    r = bus_rdata;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic wait_for(input int n, input bit on_done);
    for (int k = 0; k < 3000; k++) begin
      if ((on_done ? nd : ns) >= n) break;
      @(negedge clk);
    end
  endtask

  typedef struct packed {
    logic        w;
    logic [1:0]  cpu;
    logic [11:0] a;
    logic [31:0] d;
    logic        chk;
    logic [31:0] e;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 2'd0, 12'h248, 32'h0000_8002, 1'b0, 32'h0},  // R1 claim: flush, range, notify
    '{1'b1, 2'd1, 12'h248, 32'h0000_0001, 1'b0, 32'h0},  // R1 dropped
    '{1'b0, 2'd1, 12'h248, 32'h0,         1'b1, 32'h0000_8002},
    '{1'b1, 2'd0, 12'h24C, 32'h0000_1000, 1'b0, 32'h0},
    '{1'b1, 2'd1, 12'h24C, 32'h0000_5555, 1'b0, 32'h0},  // R1 dropped
    '{1'b1, 2'd0, 12'h250, 32'h0000_0200, 1'b0, 32'h0},
    '{1'b0, 2'd0, 12'h24C, 32'h0,         1'b1, 32'h0000_1000},
    '{1'b0, 2'd1, 12'h25C, 32'h0,         1'b1, 32'h1},  // R3 non-owner
    '{1'b0, 2'd0, 12'h25C, 32'h0,         1'b1, 32'h0},  // R2 accepted
    '{1'b0, 2'd2, 12'h25C, 32'h0,         1'b1, 32'h1},  // R3 no mode write
    '{1'b1, 2'd1, 12'h248, 32'h0002_0001, 1'b0, 32'h0},  // R4 clean, all, no notify
    '{1'b1, 2'd1, 12'h24C, 32'h000D_EAD0, 1'b0, 32'h0},
    '{1'b1, 2'd1, 12'h258, 32'h0000_0007, 1'b0, 32'h0},
    '{1'b0, 2'd1, 12'h25C, 32'h0,         1'b1, 32'h0},
    '{1'b1, 2'd3, 12'h248, 32'h0042_8005, 1'b0, 32'h0},  // R4 touch, all, by way, notify
    '{1'b1, 2'd3, 12'h258, 32'h0000_0003, 1'b0, 32'h0},
    '{1'b1, 2'd3, 12'h254, 32'h0000_FFF0, 1'b0, 32'h0},
    '{1'b0, 2'd3, 12'h254, 32'h0,         1'b1, 32'h0000_FFF0},
    '{1'b0, 2'd3, 12'h25C, 32'h0,         1'b1, 32'h0},
    '{1'b0, 2'd3, 12'h25C, 32'h0,         1'b1, 32'h1},  // R3 after release
    '{1'b0, 2'd0, 12'h260, 32'h0,         1'b1, 32'h3}   // R8 busy and waiting
  };

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11 reset state
    check("R11 ready", {31'd0, bus_ready}, 32'h1);
    check("R11 start", {31'd0, exec_start}, 32'h0);
    check("R11 pf", {31'd0, pf_flush}, 32'h0);
    bus_op(1'b0, 2'd0, A_QST, 32'h0, r);  check("R11 qstat", r, 32'h0);
    bus_op(1'b0, 2'd2, A_MODE, 32'h0, r); check("R11 mode", r, 32'h0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      bus_op(VEC[i].w, VEC[i].cpu, VEC[i].a, VEC[i].d, r);
      if (VEC[i].chk) check($sformatf("R1/R2/R3/R8 row %0d", i), r, VEC[i].e);
    end

    // R4 R5 R6 order, fields, latency
    wait_for(3, 1'b1);
    check("R5 starts", ns, 3);
    check("R5 cpu0", {30'd0, st_cpu[0]}, 32'd0);
    check("R4 cmd0", {28'd0, st_cmd[0]}, 32'd2);
    check("R4 addr0", st_addr[0], 32'h1000);
    check("R4 size0", st_size[0], 32'h200);
    check("R4 way0", st_way[0], 32'h0);
    check("R5 cpu1", {30'd0, st_cpu[1]}, 32'd1);
    check("R4 addr1", st_addr[1], 32'h0);
    check("R4 way1", st_way[1], 32'h0);
    check("R5 cpu2", {30'd3, st_cpu[2]} & 32'h3, 32'd3);
    check("R4 cmd2", {28'd0, st_cmd[2]}, 32'd5);
    check("R4 way2", st_way[2], 32'h3);
    check("R6 latency", dn_cyc[0] - st_cyc[0], LAT);
    check("R5 serial", {31'd0, st_cyc[1] > dn_cyc[0]}, 32'h1);
    repeat (2) @(negedge clk);

    // R7 flags
    bus_op(1'b0, 2'd0, A_QST, 32'h0, r); check("R7 cpu0 flag", r, 32'h4);
    bus_op(1'b0, 2'd1, A_QST, 32'h0, r); check("R7 cpu1 no notify", r, 32'h0);
    bus_op(1'b1, 2'd0, A_QST, 32'h4, r);
    bus_op(1'b0, 2'd0, A_QST, 32'h0, r); check("R7 clear", r, 32'h0);
    bus_op(1'b1, 2'd3, A_QST, 32'h0, r);
    bus_op(1'b0, 2'd3, A_QST, 32'h0, r); check("R7 zero write ignored", r, 32'h4);
    bus_op(1'b1, 2'd3, A_QST, 32'h4, r);

    // R2 full queue
    for (int k = 0; k < 6; k++) begin
      bus_op(1'b1, 2'd2, A_MODE, 32'h0002_0000, r);
      bus_op(1'b0, 2'd2, A_SETC, 32'h0, r);
      check($sformatf("R2 fill %0d", k), r, (k == 5) ? 32'h2 : 32'h0);
    end
    bus_op(1'b0, 2'd2, A_SETC, 32'h0, r); check("R2 released after full", r, 32'h1);

    // R10 prefetch strobe
    bus_op(1'b1, 2'd0, A_PRIM, 32'h9, r); check("R10 strobe", {31'd0, pf_flush}, 32'h1);
    @(negedge clk); check("R10 one cycle", {31'd0, pf_flush}, 32'h0);
    bus_op(1'b1, 2'd0, A_PRIM, 32'h8, r); check("R10 sync no strobe", {31'd0, pf_flush}, 32'h0);

    // R9 stall until drained
    bus_valid = 1'b1; bus_write = 1'b0; bus_cpu = 2'd0; bus_addr = A_PRIM;
    #1; check("R9 stall", {31'd0, bus_ready}, 32'h0);
    @(negedge clk); bus_valid = 1'b0;
    bus_op(1'b0, 2'd0, A_PRIM, 32'h0, r); check("R9 read value", r, 32'h0);
    bus_op(1'b0, 2'd0, A_QST, 32'h0, r);  check("R9 drained", r, 32'h0);

    // R7 set and clear in one cycle
    bus_op(1'b1, 2'd1, A_MODE, 32'h0002_8000, r);
    bus_op(1'b0, 2'd1, A_SETC, 32'h0, r);
    for (int k = 0; k < 200; k++) begin
      if (exec_done) break;
      @(negedge clk);
    end
    check("R6 done seen", {31'd0, exec_done}, 32'h1);
    bus_op(1'b1, 2'd1, A_QST, 32'h4, r);
    bus_op(1'b0, 2'd1, A_QST, 32'h0, r); check("R7 set wins", r, 32'h4);

    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", ntest, nfail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      ntest++; nfail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", ntest, nfail);
      $finish;
    end
  end
endmodule